// File: doc/BRIEF.md
# Multi-Depth Framebuffer Pixel Unpacker

This block turns a stream of 32-bit framebuffer words into pixels, one pixel on each accepted output beat, for a single display line at a time. A fetch engine upstream supplies the words over a valid/ready handshake. A scan-out pipeline downstream takes either an 8-bit palette index or a 24-bit direct colour value, together with a flag on the last pixel of the line.

The pixel depth is chosen by a 3-bit code and ranges from 1 to 32 bits per pixel. Two ordering controls change where each pixel sits inside a word. One reverses the whole word byte-wise, so that the first pixel comes from the most significant end. The other reverses only the pixel order inside each byte, for depths below 8. A colour-order bit chooses which end of a direct-colour pixel carries red. The block also reports how many source bytes one line takes at the current depth and column count, so the fetch side can size its reads.

The configuration inputs are expected to hold steady while a line is in flight. They change only between lines, when the block holds no word.

Top module: `pxu_unpack`

## Requirements
- R1: While reset is active and after its release, until a word has been accepted, `out_valid` is 0 and `in_ready` is 1.
- R2: `line_bytes` equals cols>>3, cols>>2, cols>>1, cols, cols<<1 or cols<<2 for depth codes 0, 1, 2, 3, 4 and 5 respectively. These codes mean 1, 2, 4, 8, 16 and 32 bits per pixel.
- R3: With both ordering controls clear, pixel k of a word is taken from bits [k*bpp +: bpp], so the first pixel comes from the least significant bits.
- R4: With `cfg_be_pix`=1 and `cfg_be_byte`=0 at depths below 8, bytes are still consumed from byte 0 upward, but within each byte the first pixel comes from the most significant bits. At depths of 8 and above, this control has no effect on the output.
- R5: With `cfg_be_byte`=1, pixel k is taken from bits [32-(k+1)*bpp +: bpp], so the first pixel comes from the most significant end of the word. This applies whatever the value of `cfg_be_pix`.
- R6: For depth codes 0 to 3, `out_is_index`=1, `out_index` is the zero-extended pixel value and `out_rgb`=0. For codes 4 and above, `out_is_index`=0 and `out_index`=0.
- R7: At code 4, the pixel holds three 5-bit fields at bits [4:0], [9:5] and [14:10]. Bit 15 is ignored. Each field is widened to 8 bits by a left shift of 3, with zero low bits.
- R8: At code 5, the pixel holds three 8-bit fields at bits [7:0], [15:8] and [23:16]. Bits [31:24] are ignored.
- R9: `out_rgb` is {red, green, blue} with 8 bits each, and green is always the middle field. With `cfg_bgr`=1, blue is the lowest field and red the highest. With `cfg_bgr`=0, the two are swapped.
- R10: `out_eol` is 1 exactly on the cols-th pixel of each line. Any pixels remaining in that word are dropped, and the next line starts at the least-significant-slot position of a fresh word.
- R11: `in_ready` is 1 only when the block holds no word, or when the last pixel still needed from the held word is being accepted (`out_ready`=1) in that same cycle. A word accepted then is presented on the next cycle, with no gap.
- R12: Depth codes 6 and 7 behave exactly as code 5, for both the pixel path and `line_bytes`.
- R13: While `out_valid`=1 and `out_ready`=0, `out_valid` and all pixel outputs hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_depth | input | 3 | Depth code (0:1, 1:2, 2:4, 3:8, 4:16, 5-7:32 bits per pixel) |
| cfg_be_byte | input | 1 | Take pixels from the most significant end of the word |
| cfg_be_pix | input | 1 | Most-significant-first pixel order inside each byte, depths below 8 |
| cfg_bgr | input | 1 | Colour order select for direct colour |
| cfg_cols | input | COLS_W | Pixels per line, at least 1 |
| in_valid | input | 1 | Source word available |
| in_data | input | 32 | Source word |
| in_ready | output | 1 | Word accepted when high together with in_valid |
| out_valid | output | 1 | A pixel is presented |
| out_ready | input | 1 | Consumer takes the pixel |
| out_index | output | 8 | Palette index for depths up to 8 |
| out_is_index | output | 1 | Pixel is an index rather than direct colour |
| out_rgb | output | 24 | Direct colour {red, green, blue} |
| out_eol | output | 1 | Pixel is the last of the line |
| line_bytes | output | COLS_W+2 | Source bytes per line at the current configuration |

## Verification
The assertions take for granted that `cfg_cols` is never zero. They also assume that the depth, ordering, colour-order and column inputs stay constant from the first word of a line until the block has emptied after its last pixel. The stability and end-of-line properties mean nothing if a line can be reshaped mid-flight. The bench changes configuration only after its reference model shows the block empty with every line complete. It always supplies whole lines of words and draws `cfg_cols` from values of 1 or more. Its random valid and ready patterns change only the timing, never the contents of a line.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

  localparam int PXU_WORD_W = 32;
  localparam int PXU_LG_W   = 3;
  localparam int PXU_SLOT_W = 5;

  // Depth code to log2(bits per pixel); codes above 5 fold to 32 bpp.
  function automatic logic [PXU_LG_W-1:0] depth_lg(input logic [2:0] code);
    return (code > 3'd5) ? 3'd5 : code;
  endfunction

  // Index of the last pixel slot in one word.
  function automatic logic [PXU_SLOT_W-1:0] slot_top(input logic [PXU_LG_W-1:0] lg);
    logic [5:0] n;
    n = (6'd32 >> lg) - 6'd1;
    return n[PXU_SLOT_W-1:0];
  endfunction

  // Bit position of slot k; the ordering modes are an XOR on the
  // slot-aligned bits of the natural position.
  function automatic logic [PXU_SLOT_W-1:0] bit_offset(
    input logic [PXU_SLOT_W-1:0] k,
    input logic [PXU_LG_W-1:0]   lg,
    input logic                  be_byte,
    input logic                  be_pix
  );
    logic [PXU_SLOT_W-1:0] base;
    logic [PXU_SLOT_W-1:0] above;
    logic [PXU_SLOT_W-1:0] flip;
    base  = k << lg;
    above = 5'b11111 << lg;
    if (be_byte)
      flip = above;
    else if (be_pix && (lg < 3'd3))
      flip = above & 5'b00111;
    else
      flip = '0;
    return base ^ flip;
  endfunction

  function automatic logic [PXU_WORD_W-1:0] field_mask(input logic [PXU_LG_W-1:0] lg);
    logic [5:0] bpp;
    bpp = 6'd1 << lg;
    if (lg >= 3'd5)
      return '1;
    return (32'd1 << bpp) - 32'd1;
  endfunction

  function automatic logic [31:0] line_bytes_calc(
    input logic [31:0]          cols,
    input logic [PXU_LG_W-1:0]  lg
  );
    if (lg < 3'd3)
      return cols >> (3'd3 - lg);
    return cols << (lg - 3'd3);
  endfunction

  function automatic logic [7:0] widen5(input logic [4:0] f);
    return {f, 3'b000};
  endfunction

endpackage

// File: rtl/pxu_line_count.sv
module pxu_line_count #(
  parameter int COLS_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [COLS_W-1:0] cols,
  output logic              line_last
);

  logic [COLS_W-1:0] col_q;
  logic [COLS_W-1:0] col_end;

  assign col_end   = cols - COLS_W'(1);
  assign line_last = (col_q == col_end);

  always_ff @(posedge clk) begin
    if (!rst_n)
      col_q <= '0;
    else if (fire)
      col_q <= line_last ? '0 : col_q + COLS_W'(1);
  end

endmodule

// File: rtl/pxu_word_hold.sv
module pxu_word_hold
  import pxu_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PXU_LG_W-1:0]   lg,
  input  logic                  in_valid,
  input  logic [PXU_WORD_W-1:0] in_data,
  output logic                  in_ready,
  input  logic                  out_ready,
  input  logic                  line_last,
  output logic                  full,
  output logic [PXU_WORD_W-1:0] word,
  output logic [PXU_SLOT_W-1:0] slot,
  output logic                  word_done,
  output logic                  fire
);

  logic take;

  assign word_done = full && ((slot == slot_top(lg)) || line_last);
  assign fire      = full && out_ready;
  assign in_ready  = !full || (out_ready && word_done);
  assign take      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
      slot <= '0;
    end else if (take) begin
      full <= 1'b1;
      word <= in_data;
      slot <= '0;
    end else if (fire) begin
      if (word_done) begin
        full <= 1'b0;
        slot <= '0;
      end else begin
        slot <= slot + PXU_SLOT_W'(1);
      end
    end
  end

endmodule

// File: rtl/pxu_pick.sv
module pxu_pick
  import pxu_pkg::*;
(
  input  logic [PXU_WORD_W-1:0] word,
  input  logic [PXU_SLOT_W-1:0] slot,
  input  logic [PXU_LG_W-1:0]   lg,
  input  logic                  be_byte,
  input  logic                  be_pix,
  output logic [PXU_WORD_W-1:0] raw
);

  logic [PXU_SLOT_W-1:0] off;

  always_comb begin
    off = bit_offset(slot, lg, be_byte, be_pix);
    raw = (word >> off) & field_mask(lg);
  end

endmodule

// File: rtl/pxu_format.sv
module pxu_format
  import pxu_pkg::*;
(
  input  logic [PXU_WORD_W-1:0] raw,
  input  logic [PXU_LG_W-1:0]   lg,
  input  logic                  bgr,
  output logic [7:0]            index,
  output logic                  is_index,
  output logic [23:0]           rgb
);

  logic [7:0] f_lo, f_mid, f_hi;

  always_comb begin
    if (lg == 3'd4) begin
      f_lo  = widen5(raw[4:0]);
      f_mid = widen5(raw[9:5]);
      f_hi  = widen5(raw[14:10]);
    end else begin
      f_lo  = raw[7:0];
      f_mid = raw[15:8];
      f_hi  = raw[23:16];
    end
    if (lg <= 3'd3) begin
      is_index = 1'b1;
      index    = raw[7:0];
      rgb      = '0;
    end else begin
      is_index = 1'b0;
      index    = '0;
      rgb      = bgr ? {f_hi, f_mid, f_lo} : {f_lo, f_mid, f_hi};
    end
  end

endmodule

// File: rtl/pxu_unpack.sv
module pxu_unpack
  import pxu_pkg::*;
#(
  parameter int COLS_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_depth,
  input  logic              cfg_be_byte,
  input  logic              cfg_be_pix,
  input  logic              cfg_bgr,
  input  logic [COLS_W-1:0] cfg_cols,
  input  logic              in_valid,
  input  logic [31:0]       in_data,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_index,
  output logic              out_is_index,
  output logic [23:0]       out_rgb,
  output logic              out_eol,
  output logic [COLS_W+1:0] line_bytes
);

  localparam int LB_W = COLS_W + 2;

  logic [PXU_LG_W-1:0]   lg;
  logic                  line_last;
  logic                  full;
  logic [PXU_WORD_W-1:0] word;
  logic [PXU_SLOT_W-1:0] slot;
  logic                  word_done;
  logic                  fire;
  logic [PXU_WORD_W-1:0] raw;
  logic [31:0]           lb_full;

  assign lg = depth_lg(cfg_depth);

  pxu_word_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .lg        (lg),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .line_last (line_last),
    .full      (full),
    .word      (word),
    .slot      (slot),
    .word_done (word_done),
    .fire      (fire)
  );

  pxu_line_count #(.COLS_W(COLS_W)) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .cols      (cfg_cols),
    .line_last (line_last)
  );

  pxu_pick u_pick (
    .word    (word),
    .slot    (slot),
    .lg      (lg),
    .be_byte (cfg_be_byte),
    .be_pix  (cfg_be_pix),
    .raw     (raw)
  );

  pxu_format u_fmt (
    .raw      (raw),
    .lg       (lg),
    .bgr      (cfg_bgr),
    .index    (out_index),
    .is_index (out_is_index),
    .rgb      (out_rgb)
  );

  assign out_valid  = full;
  assign out_eol    = full && line_last;
  assign lb_full    = line_bytes_calc(32'(cfg_cols), lg);
  assign line_bytes = lb_full[LB_W-1:0];

endmodule

// File: rtl/pxu_unpack_chk.sv
module pxu_unpack_chk #(
  parameter int COLS_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cfg_depth,
  input logic [COLS_W-1:0] cfg_cols,
  input logic [COLS_W+1:0] line_bytes,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_index,
  input logic              out_is_index,
  input logic [23:0]       out_rgb,
  input logic              out_eol,
  input logic              word_done
);

  logic [COLS_W-1:0] seen_q;
  logic              took;

  assign took = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)
      seen_q <= '0;
    else if (took)
      seen_q <= out_eol ? '0 : seen_q + COLS_W'(1);
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R1

  AST_LINE_BYTES_BYTEWIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_depth == 3'd3) |-> (line_bytes == (COLS_W+2)'(cfg_cols))); // R2

  AST_INDEX_NO_COLOUR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_depth <= 3'd3) |-> (out_is_index && out_rgb == 24'd0)); // R6

  AST_COLOUR_NO_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_depth > 3'd3) |-> (!out_is_index && out_index == 8'd0)); // R6

  AST_FIVE_BIT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_depth == 3'd4) |->
      (out_rgb[2:0] == 3'd0 && out_rgb[10:8] == 3'd0 && out_rgb[18:16] == 3'd0)); // R7

  AST_EOL_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
    took |-> (out_eol == (seen_q == cfg_cols - COLS_W'(1)))); // R10

  AST_EOL_ENDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eol) |-> word_done); // R10

  AST_NO_TAKE_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R11

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_index) && $stable(out_rgb) && $stable(out_eol))); // R13

endmodule

bind pxu_unpack pxu_unpack_chk #(.COLS_W(COLS_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_depth    (cfg_depth),
  .cfg_cols     (cfg_cols),
  .line_bytes   (line_bytes),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_index    (out_index),
  .out_is_index (out_is_index),
  .out_rgb      (out_rgb),
  .out_eol      (out_eol),
  .word_done    (word_done)
);

// File: tb/tb_pxu_unpack.sv
module tb_pxu_unpack;

  localparam int CLK_PERIOD = 10;
  localparam int COLS_W     = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        cfg_depth = 3'd0;
  logic              cfg_be_byte = 1'b0;
  logic              cfg_be_pix = 1'b0;
  logic              cfg_bgr = 1'b0;
  logic [COLS_W-1:0] cfg_cols = 12'd8;
  logic              in_valid = 1'b0;
  logic [31:0]       in_data = 32'd0;
  logic              in_ready;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [7:0]        out_index;
  logic              out_is_index;
  logic [23:0]       out_rgb;
  logic              out_eol;
  logic [COLS_W+1:0] line_bytes;

  int  n_tests = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pxu_unpack #(.COLS_W(COLS_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_be_byte(cfg_be_byte),
    .cfg_be_pix(cfg_be_pix), .cfg_bgr(cfg_bgr), .cfg_cols(cfg_cols),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_index(out_index),
    .out_is_index(out_is_index), .out_rgb(out_rgb), .out_eol(out_eol),
    .line_bytes(line_bytes)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Pixel k of a word, read bit by bit in the order each mode defines.
  function automatic int ref_raw(input logic [31:0] w, input int k, input int bpp,
                                 input bit beb, input bit bep);
    int v = 0;
    int top;
    if (beb) begin
      top = 31 - k * bpp;
      for (int b = 0; b < bpp; b++) v = (v << 1) | int'(w[top - b]);
    end else if (bep && bpp < 8) begin
      top = ((k * bpp) / 8) * 8 + 7 - ((k * bpp) % 8);
      for (int b = 0; b < bpp; b++) v = (v << 1) | int'(w[top - b]);
    end else begin
      for (int b = 0; b < bpp; b++) v = v | (int'(w[k * bpp + b]) << b);
    end
    return v;
  endfunction

  task automatic run_cfg(input int code, input bit beb, input bit bep, input bit bgr,
                         input int ncols, input int nlines, input int rdy_pct, input int vld_pct);
    logic [31:0] wq[$];
    int   bpp, ppw, nw, pixels, guard, ch0, ch1, ch2, red, blu, val;
    bit   m_full, m_last, exp_rdy, hold_prev, fire;
    logic [31:0] m_word;
    int   m_k, m_col;
    logic [7:0] p_idx; logic [23:0] p_rgb; logic p_eol;
    string otag, ctag;
    bpp = (code >= 5) ? 32 : (1 << code);
    ppw = 32 / bpp;
    nw  = (ncols + ppw - 1) / ppw;
    otag = beb ? "R5" : (bep ? "R4" : "R3");
    ctag = (code >= 6) ? "R12" : (!bgr ? "R9" : (bpp == 16 ? "R7" : "R8"));
    for (int l = 0; l < nlines; l++)
      for (int i = 0; i < nw; i++) wq.push_back($urandom);
    @(negedge clk);
    cfg_depth = 3'(code); cfg_be_byte = beb; cfg_be_pix = bep; cfg_bgr = bgr;
    cfg_cols = COLS_W'(ncols);
    m_full = 0; m_k = 0; m_col = 0; pixels = 0; guard = 0; hold_prev = 0;
    p_idx = '0; p_rgb = '0; p_eol = 0; m_word = '0;
    while ((wq.size() > 0 || m_full) && guard < 20000) begin
      guard++;
      @(negedge clk);
      in_valid  = (wq.size() > 0) && (($urandom % 100) < vld_pct);
      in_data   = in_valid ? wq[0] : $urandom;
      out_ready = (($urandom % 100) < rdy_pct);
      #1;
      m_last  = m_full && ((m_k == ppw - 1) || (m_col == ncols - 1));
      exp_rdy = !m_full || (out_ready && m_last);
      chk("R11", "out_valid", out_valid, m_full);
      chk("R11", "in_ready", in_ready, exp_rdy);
      if (hold_prev) begin
        chk("R13", "held index", out_index, p_idx);
        chk("R13", "held rgb", out_rgb, p_rgb);
        chk("R13", "held eol", out_eol, p_eol);
      end
      if (m_full) begin
        val = ref_raw(m_word, m_k, bpp, beb, bep);
        chk("R10", "eol", out_eol, (m_col == ncols - 1));
        if (bpp <= 8) begin
          chk("R6", "is_index", out_is_index, 1);
          chk(otag, "index", out_index, val);
          chk("R6", "rgb zero", out_rgb, 0);
        end else begin
          if (bpp == 16) begin
            ch0 = (val & 31) * 8; ch1 = ((val >> 5) & 31) * 8; ch2 = ((val >> 10) & 31) * 8;
          end else begin
            ch0 = val & 255; ch1 = (val >> 8) & 255; ch2 = (val >> 16) & 255;
          end
          red = bgr ? ch2 : ch0;
          blu = bgr ? ch0 : ch2;
          chk("R6", "is_index", out_is_index, 0);
          chk("R6", "index zero", out_index, 0);
          chk(ctag, "rgb", out_rgb, (red << 16) | (ch1 << 8) | blu);
        end
      end
      hold_prev = m_full && !out_ready;
      p_idx = out_index; p_rgb = out_rgb; p_eol = out_eol;
      fire = m_full && out_ready;
      if (fire) begin
        pixels++;
        m_col = (m_col == ncols - 1) ? 0 : m_col + 1;
      end
      if (in_valid && exp_rdy) begin
        m_full = 1; m_word = wq.pop_front(); m_k = 0;
      end else if (fire) begin
        if (m_last) m_full = 0; else m_k++;
      end
    end
    @(negedge clk);
    in_valid = 0; out_ready = 0;
    chk("R10", "pixels per run", pixels, ncols * nlines);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int exp_lb;
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", out_valid, 0);
    chk("R1", "ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "valid after reset", out_valid, 0);
    chk("R1", "ready after reset", in_ready, 1);

    cfg_cols = 12'd200;
    for (int c = 0; c < 8; c++) begin
      cfg_depth = 3'(c);
      #1;
      exp_lb = (c < 3) ? (200 >> (3 - c)) : (c == 3 ? 200 : (c == 4 ? 400 : 800));
      chk(c >= 6 ? "R12" : "R2", "line_bytes", line_bytes, exp_lb);
      @(negedge clk);
    end

    for (int c = 0; c < 6; c++)
      for (int m = 0; m < 4; m++)
        run_cfg(c, m[1], m[0], m[0] ^ m[1], 37, 2, 70, 80);
    run_cfg(3, 0, 0, 0, 1, 3, 60, 60);
    run_cfg(0, 0, 1, 0, 1, 2, 100, 100);
    run_cfg(6, 0, 0, 1, 5, 2, 70, 70);
    run_cfg(7, 1, 0, 0, 5, 2, 70, 70);
    run_cfg(4, 0, 0, 1, 64, 2, 100, 100);
    run_cfg(2, 1, 1, 0, 19, 3, 100, 100);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule